// File: doc/BRIEF.md
# Column Offset Calibration Store

This block removes column-wise fixed offsets from a stream of digitized pixel samples. Each sample arrives with its column index. The column picks one of 167 shared converter channels, and each channel serves four adjacent columns. The block subtracts that channel's stored 7-bit offset from the 10-bit sample. The result is clamped so it never falls below zero.

The offsets are measured by the block itself. A calibration row captures one sample per channel as the new offset. One such row runs automatically after reset is released. A control bit can also re-arm a calibration row at every frame start, and this repeats until the host writes the bit back to zero.

A small register port lets the host read any offset and overwrite it. A host write is held back so that it only takes effect from the next row. This keeps every row corrected with one consistent set of offsets.

Top module: `colOffsetStore`

## Requirements
- R1: After reset, `outValid` and `calRowActive` are 0, and `cfgRdData` is 0 until the first read. A calibration is pending, so the first row started after reset is a calibration row.
- R2: A column `c` maps to channel `c / 4`. Columns 0 to 667 cover channels 0 to 166, and columns past the last group map to channel 166.
- R3: During a calibration row, a valid sample on a column with `c % 4 == 0` stores `min(sample, 127)` as that channel's offset. Samples on all other columns leave the offsets unchanged.
- R4: While a calibration row is active, `calRowActive` is 1 and no corrected output is produced: `outValid` stays 0.
- R5: Outside a calibration row, every valid sample gives `outValid` = 1 one clock later, with `outData = sample - offset[channel]`. A cycle without a valid sample gives `outValid` = 0 one clock later.
- R6: When the offset is larger than the sample, `outData` is 0. The subtraction never wraps.
- R7: Bit 0 of the control register at address 255 enables continuous recalibration. While it is 1, each `frameStart` arms a calibration row for the next `rowStart`. While it is 0, frame starts arm nothing. `calRowActive` rises only one clock after a `rowStart`.
- R8: A host write to address `a` (0 to 166) replaces offset `a` in the host view at once. The correction path uses the new value only after the next `rowStart`, never for the rest of the current row.
- R9: `cfgRdData` shows the register at `cfgAddr` one clock later. Addresses 0 to 166 return the host view of that offset. Address 255 returns the enable in bit 0 with the upper bits 0. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | One-cycle pulse at the start of a frame |
| rowStart | input | 1 | One-cycle pulse at the start of a row |
| sampleValid | input | 1 | A sample is present this cycle |
| sampleCol | input | 10 | Column index of the sample |
| sampleIn | input | 10 | Raw converted sample |
| cfgWrEn | input | 1 | Host register write strobe |
| cfgAddr | input | 8 | Host register address |
| cfgWrData | input | 7 | Host write data |
| cfgRdData | output | 7 | Registered host read data |
| outValid | output | 1 | Corrected sample valid |
| outData | output | 10 | Corrected sample |
| calRowActive | output | 1 | Current row is a calibration row |

## Verification
The first calibration row uses random values from 0 to 160. Values above 127 show the capture clamp, and samples on unaligned columns show whether the wrong column in a group was captured. Normal rows are driven with full-range random samples, which checks the subtraction and the column-to-channel mapping. Low-value rows push most results below zero and so exercise the clamp at zero.

A directed host write in the middle of a row separates the host view from the active copy. The continuous-recalibration sequence checks that a frame start arms a calibration row only while the enable is set.

// File: rtl/colOffsetStorePkg.sv
package colOffsetStorePkg;
  typedef struct packed {
    logic loadActive;  // copy host view into active offsets
    logic calRow;      // current row captures offsets
    logic coefWr;      // host write to an offset entry
  } calStrobe_t;
endpackage

// File: rtl/colOffsetCtrl.sv
module colOffsetCtrl
  import colOffsetStorePkg::*;
#(
  parameter int NUM_CH = 167,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              rowStart,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              ctrlBit,
  output calStrobe_t        strb,
  output logic              contCal
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  logic calPending;
  logic calRow;
  logic ctrlWr;
  logic armNow;

  assign ctrlWr = cfgWrEn && (cfgAddr == CTRL_ADDR);
  assign armNow = calPending || (frameStart && contCal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calPending <= 1'b1;   // automatic calibration after reset
      calRow     <= 1'b0;
      contCal    <= 1'b0;
    end else begin
      if (ctrlWr) contCal <= ctrlBit;
      if (rowStart) begin
        calRow     <= armNow;
        calPending <= 1'b0;
      end else if (frameStart && contCal) begin
        calPending <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.loadActive = rowStart;
    strb.calRow     = calRow;
    strb.coefWr     = cfgWrEn && (cfgAddr < ADDR_W'(NUM_CH));
  end
endmodule

// File: rtl/colOffsetPath.sv
module colOffsetPath
  import colOffsetStorePkg::*;
#(
  parameter int NUM_CH = 167,
  parameter int GROUP  = 4,
  parameter int OFS_W  = 7,
  parameter int SMP_W  = 10,
  parameter int ADDR_W = 8,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic              sampleValid,
  input  logic [COL_W-1:0]  sampleCol,
  input  logic [SMP_W-1:0]  sampleIn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [OFS_W-1:0]  coefWrData,
  input  logic              contCal,
  output logic              outValid,
  output logic [SMP_W-1:0]  outData,
  output logic [OFS_W-1:0]  cfgRdData
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [COL_W-1:0]  GRP       = COL_W'(GROUP);
  localparam logic [COL_W-1:0]  LAST_GRP  = COL_W'(NUM_CH - 1);
  localparam logic [OFS_W-1:0]  OFS_MAX   = '1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  logic [OFS_W-1:0] stageMem  [NUM_CH];
  logic [OFS_W-1:0] activeMem [NUM_CH];

  logic [COL_W-1:0] colGroup;
  logic [CH_W-1:0]  sampleCh;
  logic [CH_W-1:0]  addrCh;
  logic             colAligned;
  logic             capEn;
  logic [OFS_W-1:0] capVal;
  logic [SMP_W-1:0] ofsExt;
  logic [SMP_W-1:0] corrected;

  // column to channel, clamped to the last channel
  assign colGroup   = sampleCol / GRP;
  assign colAligned = (sampleCol % GRP) == '0;
  assign sampleCh   = (colGroup > LAST_GRP) ? CH_W'(NUM_CH - 1) : CH_W'(colGroup);
  assign addrCh     = CH_W'(cfgAddr);

  assign capEn  = strb.calRow && sampleValid && colAligned;
  assign capVal = (sampleIn > SMP_W'(OFS_MAX)) ? OFS_MAX : sampleIn[OFS_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : gEntry
    logic capHit;
    logic hostHit;
    assign capHit  = capEn && (sampleCh == CH_W'(g));
    assign hostHit = strb.coefWr && (addrCh == CH_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageMem[g]  <= '0;
        activeMem[g] <= '0;
      end else begin
        if (capHit)       stageMem[g] <= capVal;
        else if (hostHit) stageMem[g] <= coefWrData;

        if (capHit)                activeMem[g] <= capVal;
        else if (strb.loadActive)  activeMem[g] <= stageMem[g];
      end
    end
  end

  // saturating subtraction
  assign ofsExt    = SMP_W'(activeMem[sampleCh]);
  assign corrected = (sampleIn < ofsExt) ? '0 : (sampleIn - ofsExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= sampleValid && !strb.calRow;
      if (sampleValid && !strb.calRow) outData <= corrected;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRdData <= '0;
    end else if (cfgAddr == CTRL_ADDR) begin
      cfgRdData <= OFS_W'(contCal);
    end else if (cfgAddr < ADDR_W'(NUM_CH)) begin
      cfgRdData <= stageMem[addrCh];
    end else begin
      cfgRdData <= '0;
    end
  end
endmodule

// File: rtl/colOffsetStore.sv
module colOffsetStore
  import colOffsetStorePkg::*;
#(
  parameter int NUM_CH = 167,
  parameter int GROUP  = 4,
  parameter int OFS_W  = 7,
  parameter int SMP_W  = 10,
  parameter int ADDR_W = 8,
  parameter int COL_W  = $clog2(NUM_CH * GROUP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              rowStart,
  input  logic              sampleValid,
  input  logic [COL_W-1:0]  sampleCol,
  input  logic [SMP_W-1:0]  sampleIn,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [OFS_W-1:0]  cfgWrData,
  output logic [OFS_W-1:0]  cfgRdData,
  output logic              outValid,
  output logic [SMP_W-1:0]  outData,
  output logic              calRowActive
);
  calStrobe_t strb;
  logic       contCal;

  colOffsetCtrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rowStart(rowStart),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .ctrlBit(cfgWrData[0]),
    .strb(strb), .contCal(contCal)
  );

  colOffsetPath #(
    .NUM_CH(NUM_CH), .GROUP(GROUP), .OFS_W(OFS_W), .SMP_W(SMP_W),
    .ADDR_W(ADDR_W), .COL_W(COL_W)
  ) path_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleValid(sampleValid),
    .sampleCol(sampleCol), .sampleIn(sampleIn), .cfgAddr(cfgAddr),
    .coefWrData(cfgWrData), .contCal(contCal), .outValid(outValid),
    .outData(outData), .cfgRdData(cfgRdData)
  );

  assign calRowActive = strb.calRow;
endmodule

// File: rtl/colOffsetStoreChk.sv
module colOffsetStoreChk #(
  parameter int OFS_W  = 7,
  parameter int SMP_W  = 10,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rowStart,
  input logic              sampleValid,
  input logic [SMP_W-1:0]  sampleIn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [OFS_W-1:0]  cfgRdData,
  input logic              outValid,
  input logic [SMP_W-1:0]  outData,
  input logic              calRowActive
);
  assert_cal_row_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (calRowActive && $past(calRowActive)) |-> !outValid);

  assert_out_follows_sample_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData <= $past(sampleIn)));

  assert_cal_starts_on_row_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calRowActive) |-> $past(rowStart));

  assert_ctrl_read_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    (&$past(cfgAddr)) |-> (cfgRdData[OFS_W-1:1] == '0));
endmodule

bind colOffsetStore colOffsetStoreChk #(
  .OFS_W(OFS_W), .SMP_W(SMP_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .rowStart(rowStart), .sampleValid(sampleValid),
  .sampleIn(sampleIn), .cfgAddr(cfgAddr), .cfgRdData(cfgRdData),
  .outValid(outValid), .outData(outData), .calRowActive(calRowActive)
);

// File: tb/colOffsetStore_tb_top.sv
module colOffsetStore_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 167;
  localparam int NCOL = 668;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0, rowStart = 1'b0, sampleValid = 1'b0;
  logic [9:0] sampleCol = '0, sampleIn = '0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = '0;
  logic [6:0] cfgWrData = '0;
  logic [6:0] cfgRdData;
  logic       outValid;
  logic [9:0] outData;
  logic       calRowActive;

  int checks = 0, errors = 0;
  int stageM [NCH];
  int actM   [NCH];
  bit pendM, contM, calM;

  always #(CLK_PERIOD/2) clk = ~clk;

  colOffsetStore dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rowStart(rowStart),
    .sampleValid(sampleValid), .sampleCol(sampleCol), .sampleIn(sampleIn),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .outValid(outValid), .outData(outData),
    .calRowActive(calRowActive)
  );

  function automatic int chOf(int col);
    return (col / 4 > NCH - 1) ? NCH - 1 : col / 4;
  endfunction

  function automatic int expOut(int col, int val);
    int o = actM[chOf(col)];
    return (val < o) ? 0 : val - o;
  endfunction

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulseFrame();
    frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
    if (contM) pendM = 1'b1;
  endtask

  task automatic pulseRow();
    rowStart = 1'b1;
    tick();
    rowStart = 1'b0;
    calM  = pendM;
    pendM = 1'b0;
    for (int i = 0; i < NCH; i++) actM[i] = stageM[i];
    chk("R7 calRowActive after rowStart", calRowActive, calM);
  endtask

  task automatic sample(int col, int val, string req);
    sampleValid = 1'b1; sampleCol = 10'(col); sampleIn = 10'(val);
    tick();
    sampleValid = 1'b0;
    if (calM) begin
      chk("R4 outValid in calibration row", outValid, 0);
      if (col % 4 == 0) begin
        stageM[chOf(col)] = (val > 127) ? 127 : val;
        actM[chOf(col)]   = stageM[chOf(col)];
      end
    end else begin
      chk(req, outValid, 1);
      chk(req, outData, expOut(col, val));
    end
  endtask

  task automatic hostWrite(int addr, int data);
    cfgWrEn = 1'b1; cfgAddr = 8'(addr); cfgWrData = 7'(data);
    tick();
    cfgWrEn = 1'b0;
    if (addr < NCH) stageM[addr] = data;
    else if (addr == 255) contM = data[0];
  endtask

  task automatic hostRead(int addr, string req);
    int e;
    cfgAddr = 8'(addr);
    tick();
    if (addr < NCH) e = stageM[addr];
    else if (addr == 255) e = contM;
    else e = 0;
    chk(req, cfgRdData, e);
  endtask

  // mode 0: full range, 1: low values, 2: calibration range
  task automatic fullRow(int mode, string req);
    pulseRow();
    for (int c = 0; c < NCOL; c++) begin
      int v;
      if (mode == 2) v = (c == 0) ? 200 : $urandom_range(0, 160);
      else if (mode == 1) v = $urandom_range(0, 20);
      else v = $urandom_range(0, 1023);
      sample(c, v, req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCH; i++) begin stageM[i] = 0; actM[i] = 0; end
    pendM = 1'b1; contM = 1'b0; calM = 1'b0;
    tick(); tick();
    chk("R1 outValid at reset", outValid, 0);
    chk("R1 calRowActive at reset", calRowActive, 0);
    chk("R1 cfgRdData at reset", cfgRdData, 0);
    rstN = 1'b1;
    tick();
    chk("R1 no output before first row", outValid, 0);

    // R1 / R3 / R4: automatic calibration row, col 0 saturates at 127
    fullRow(2, "R3 calibration capture");
    hostRead(0, "R3 capture clamp to 127");
    for (int a = 1; a < NCH; a += 17) hostRead(a, "R9 offset readback");
    hostRead(200, "R9 unused address reads 0");

    // R5 / R2 full-range correction, R6 saturation
    fullRow(0, "R5 corrected sample");
    fullRow(1, "R6 saturation at zero");

    // R5: no valid sample gives no output
    tick();
    chk("R5 idle cycle", outValid, 0);

    // R8: host write mid-row waits for next row
    pulseRow();
    for (int c = 0; c < 20; c++) sample(c, $urandom_range(0, 1023), "R5 corrected sample");
    hostWrite(5, (actM[5] + 50) % 128);
    hostRead(5, "R8 host view updated at once");
    sample(20, 500, "R8 old offset kept in row");
    sample(23, 90, "R8 old offset kept in row");
    pulseRow();
    sample(20, 500, "R8 new offset after rowStart");
    sample(22, 3, "R8 new offset after rowStart");

    // R7: frame start without enable arms nothing
    pulseFrame();
    pulseRow();
    sample(8, 700, "R7 no recalibration when disabled");

    // R7: continuous recalibration across two frames
    hostWrite(255, 1);
    hostRead(255, "R9 control readback");
    pulseFrame();
    fullRow(2, "R7 recalibration frame 1");
    fullRow(0, "R5 after recalibration");
    pulseFrame();
    fullRow(2, "R7 recalibration frame 2");
    hostWrite(255, 0);
    hostRead(255, "R9 control cleared");
    pulseFrame();
    fullRow(0, "R7 stopped after zero written");

    // R2: out-of-range column uses last channel
    pulseRow();
    sample(700, 1000, "R2 column clamp to last channel");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule